// File: doc/BRIEF.md
# Drift-Free Periodic Deadline Scheduler

The block paces a stream of output words onto a register at evenly spaced moments measured against a free-running time base. A host gives a period and a lead time and pulses a start strobe. The first deadline is the start time plus the period. Every later deadline is the previous deadline plus the period. The time at which a word actually arrives therefore never moves the schedule, so the timing cannot drift.

A fixed number of clocks before each deadline, the block pulses a request strobe so that an upstream source can fetch the next word. The block takes that word over a valid/ready handshake into a one-word holding slot. The ready line is high only between the request and the deadline, and only while the slot is empty. A source may raise valid early and hold it. Nothing transfers until ready is also high. At most one word is taken per deadline, and a word offered outside the window waits or is dropped by the source. At the deadline the held word moves to the output register. If the slot is empty, the output keeps its value and a sticky error flag rises. The fetch latency can vary anywhere inside the window without moving the output instants, provided the period exceeds the lead plus the fetch time.

Top module: `deadline_pacer`

## Requirements
- R1: `now_o` comes out of reset at the parameter value TIME_INIT, rises by one every clock, and is never cleared or reloaded by `start_i` or by any other input.
- R2: A start strobe sampled while `now_o` equals T captures `interval_i` and `lead_i` and sets the first deadline to T + interval (modulo 2^32).
- R3: Each following deadline equals the previous deadline plus the captured interval, whatever the cycle in which the word for it was transferred.
- R4: With `now_o` equal to a deadline D, `out_o` still shows its old value. The new value is visible from the cycle with `now_o` = D+1, and `out_o` changes at no other time.
- R5: `data_req_o` is high for exactly one cycle per deadline: the cycle in which `now_o` equals D − lead.
- R6: `data_ready_o` is high from the request cycle through cycle D−1 while the slot is empty. A word transfers on a clock edge where `data_valid_i` and `data_ready_o` are both high, and one transfer closes the window. A word offered while `data_ready_o` is low has no effect.
- R7: If no word has transferred by a deadline, `out_o` holds its value and `underrun_o` goes to 1. It stays 1 until the next start strobe clears it.
- R8: A start with lead = 0 or interval ≤ lead sets `cfg_err_o` and leaves the block idle: no request, no ready, and no output change. A later start with legal values clears `cfg_err_o`.
- R9: A deadline that lies past the counter's wrap point fires at the wrapped count.
- R10: After reset, `out_o`, `underrun_o`, `cfg_err_o`, `data_req_o` and `data_ready_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle strobe that (re)arms the schedule |
| interval_i | input | 32 | Period in clocks, captured on start |
| lead_i | input | 8 | Clocks between request and deadline, captured on start |
| now_o | output | 32 | Free-running time count |
| data_req_o | output | 1 | Fetch-next-word strobe |
| data_valid_i | input | 1 | Source has a word on `data_i` |
| data_ready_o | output | 1 | Block will take the word at this edge |
| data_i | input | 24 | Next output word |
| out_o | output | 24 | Paced output register |
| underrun_o | output | 1 | Sticky: a deadline passed with no word |
| cfg_err_o | output | 1 | Last start had an illegal interval/lead |

## Verification
The assertions assume that the schedule runs only with a legal configuration: a lead of at least one and a period longer than the lead. Under that assumption a request can never coincide with a deadline, and two deadlines are always at least two cycles apart. The stimulus sends illegal pairs only to exercise the rejection path and checks that the block stays quiet afterwards. It raises start only as a one-cycle strobe, driven away from the clock edge. The bench offers each word no earlier than the request and drops valid after the transfer or at the deadline, so the one-word slot is exercised at both edges of the window.

// File: rtl/sched_pkg.sv
package sched_pkg;
  // Width of the captured lead time; kept here so all stages agree.
  localparam int unsigned LEAD_W_DEF = 8;
  localparam int unsigned TIME_W_DEF = 32;
  localparam int unsigned DATA_W_DEF = 24;

  // Schedule events produced by the deadline unit.
  typedef struct packed {
    logic armed;
    logic req;
    logic win;
    logic fire;
  } sched_ev_t;
endpackage

// File: rtl/sched_timebase.sv
module sched_timebase #(
  parameter int unsigned TIME_W = 32,
  parameter logic [TIME_W-1:0] TIME_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [TIME_W-1:0] now_o
);
  logic [TIME_W-1:0] now_q;

  // Free-running count; only reset touches it.
  always_ff @(posedge clk) begin
    if (!rst_n) now_q <= TIME_INIT;
    else        now_q <= now_q + 1'b1;
  end

  assign now_o = now_q;
endmodule

// File: rtl/sched_deadline.sv
module sched_deadline
  import sched_pkg::*;
#(
  parameter int unsigned TIME_W = 32,
  parameter int unsigned LEAD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic              disarm_i,
  input  logic [TIME_W-1:0] interval_i,
  input  logic [LEAD_W-1:0] lead_i,
  input  logic [TIME_W-1:0] now_i,
  output sched_ev_t         ev_o
);
  localparam int unsigned PAD_W = TIME_W - LEAD_W;

  logic [TIME_W-1:0] ivl_q;
  logic [LEAD_W-1:0] lead_q;
  logic [TIME_W-1:0] dl_q;
  logic              armed_q;
  logic              win_q;
  logic [TIME_W-1:0] req_at;
  logic              req_hit;
  logic              fire_hit;

  // Equality on the wrapping count: crossing 2^TIME_W needs no special case.
  assign req_at   = dl_q - {{PAD_W{1'b0}}, lead_q};
  assign req_hit  = armed_q && (now_i == req_at);
  assign fire_hit = armed_q && (now_i == dl_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ivl_q   <= '0;
      lead_q  <= '0;
      dl_q    <= '0;
      armed_q <= 1'b0;
      win_q   <= 1'b0;
    end else if (arm_i) begin
      ivl_q   <= interval_i;
      lead_q  <= lead_i;
      dl_q    <= now_i + interval_i;
      armed_q <= 1'b1;
      win_q   <= 1'b0;
    end else if (disarm_i) begin
      armed_q <= 1'b0;
      win_q   <= 1'b0;
    end else if (fire_hit) begin
      // Next target comes from the old target, never from the present time.
      dl_q    <= dl_q + ivl_q;
      win_q   <= 1'b0;
    end else if (req_hit) begin
      win_q   <= 1'b1;
    end
  end

  assign ev_o.armed = armed_q;
  assign ev_o.req   = req_hit;
  assign ev_o.win   = req_hit | win_q;
  assign ev_o.fire  = fire_hit;

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_o.req && !arm_i |=> !ev_o.req); // R5
  AST_REQ_NOT_AT_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_o.req |-> !ev_o.fire); // R5
  AST_FIRE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    ev_o.fire |=> !ev_o.fire); // R3
endmodule

// File: rtl/sched_outstage.sv
module sched_outstage
  import sched_pkg::*;
#(
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  sched_ev_t         ev_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] out_o,
  output logic              underrun_o
);
  logic              have_q;
  logic [DATA_W-1:0] pend_q;
  logic [DATA_W-1:0] out_q;
  logic              ur_q;
  logic              xfer;

  assign ready_o = ev_i.armed && ev_i.win && !have_q && !ev_i.fire;
  assign xfer    = valid_i && ready_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      pend_q <= '0;
      out_q  <= '0;
      ur_q   <= 1'b0;
    end else if (clear_i) begin
      have_q <= 1'b0;
      ur_q   <= 1'b0;
    end else if (ev_i.fire) begin
      if (have_q) out_q <= pend_q;
      else        ur_q  <= 1'b1;
      have_q <= 1'b0;
    end else if (xfer) begin
      pend_q <= data_i;
      have_q <= 1'b1;
    end
  end

  assign out_o      = out_q;
  assign underrun_o = ur_q;

  AST_OUT_ONLY_AT_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_i.fire |=> $stable(out_o)); // R4
  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o && !clear_i |=> underrun_o); // R7
  AST_XFER_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && !clear_i |=> !ready_o); // R6
endmodule

// File: rtl/deadline_pacer.sv
module deadline_pacer
  import sched_pkg::*;
#(
  parameter int unsigned TIME_W = TIME_W_DEF,
  parameter int unsigned LEAD_W = LEAD_W_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter logic [TIME_W-1:0] TIME_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [TIME_W-1:0] interval_i,
  input  logic [LEAD_W-1:0] lead_i,
  output logic [TIME_W-1:0] now_o,
  output logic              data_req_o,
  input  logic              data_valid_i,
  output logic              data_ready_o,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] out_o,
  output logic              underrun_o,
  output logic              cfg_err_o
);
  localparam int unsigned PAD_W = TIME_W - LEAD_W;

  logic [TIME_W-1:0] now;
  sched_ev_t         ev;
  logic              cfg_ok;
  logic              arm;
  logic              disarm;
  logic              cfg_err_q;

  // Legal only when the lead is non-zero and strictly shorter than the period.
  assign cfg_ok = (lead_i != '0) && (interval_i > {{PAD_W{1'b0}}, lead_i});
  assign arm    = start_i && cfg_ok;
  assign disarm = start_i && !cfg_ok;

  always_ff @(posedge clk) begin
    if (!rst_n)       cfg_err_q <= 1'b0;
    else if (start_i) cfg_err_q <= !cfg_ok;
  end

  sched_timebase #(.TIME_W(TIME_W), .TIME_INIT(TIME_INIT)) u_tb (
    .clk   (clk),
    .rst_n (rst_n),
    .now_o (now)
  );

  sched_deadline #(.TIME_W(TIME_W), .LEAD_W(LEAD_W)) u_dl (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_i      (arm),
    .disarm_i   (disarm),
    .interval_i (interval_i),
    .lead_i     (lead_i),
    .now_i      (now),
    .ev_o       (ev)
  );

  sched_outstage #(.DATA_W(DATA_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (start_i),
    .ev_i       (ev),
    .valid_i    (data_valid_i),
    .data_i     (data_i),
    .ready_o    (data_ready_o),
    .out_o      (out_o),
    .underrun_o (underrun_o)
  );

  assign now_o      = now;
  assign data_req_o = ev.req;
  assign cfg_err_o  = cfg_err_q;

  AST_CFG_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |-> !data_req_o && !data_ready_o); // R8
  AST_START_NO_TIME_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> now_o != $past(now_o)); // R1
endmodule

// File: tb/deadline_pacer_tb.sv
module deadline_pacer_tb_top;
  localparam logic [31:0] T_INIT = 32'hFFFF_FF00;

  typedef struct packed {
    logic [31:0] ivl;
    logic [7:0]  ld;
    logic [7:0]  dly;
    logic [23:0] val;
    logic        ur;
  } vec_t;

  // period, lead, delay after request before valid, word, underrun expected
  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{32'd40,  8'd32, 8'd3, 24'hA5A5A5, 1'b0},
    '{32'd100, 8'd8,  8'd0, 24'h123456, 1'b0},
    '{32'd12,  8'd4,  8'd3, 24'h0F0F0F, 1'b0},  // last cycle of window
    '{32'd20,  8'd5,  8'd5, 24'hDEAD00, 1'b1},  // arrives too late
    '{32'd9,   8'd1,  8'd0, 24'h00BEEF, 1'b0},
    '{32'd64,  8'd2,  8'd1, 24'hC0FFEE, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] interval = '0;
  logic [7:0]  lead = '0;
  logic [31:0] now;
  logic        data_req;
  logic        data_valid = 1'b0;
  logic        data_ready;
  logic [23:0] data_in = '0;
  logic [23:0] out;
  logic        underrun;
  logic        cfg_err;

  int checks = 0;
  int errors = 0;
  logic [23:0] exp_out = '0;

  always #5 clk = ~clk;

  deadline_pacer #(.TIME_INIT(T_INIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .interval_i(interval),
    .lead_i(lead), .now_o(now), .data_req_o(data_req),
    .data_valid_i(data_valid), .data_ready_o(data_ready), .data_i(data_in),
    .out_o(out), .underrun_o(underrun), .cfg_err_o(cfg_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at now=%h", tag, act, exp, now);
    end
  endtask

  task automatic wait_req(output bit ok);
    ok = 1'b0;
    for (int k = 0; k < 400; k++) begin
      if (data_req) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  // Start a schedule and follow two deadlines.
  task automatic run_vec(input vec_t v);
    logic [31:0] t0, dl;
    bit ok;
    @(negedge clk);
    start = 1'b1; interval = v.ivl; lead = v.ld; t0 = now;
    @(negedge clk);
    start = 1'b0;
    chk("R7 underrun cleared by start", {31'd0, underrun}, 32'd0);
    for (int p = 0; p < 2; p++) begin
      dl = t0 + v.ivl * (p + 1);                      // R2 / R3 target
      wait_req(ok);
      chk("R5 request seen", {31'd0, ok}, 32'd1);
      chk(p == 0 ? "R5 R2 request at first deadline-lead" : "R5 R3 request at next deadline-lead",
          now, dl - {24'd0, v.ld});
      chk("R6 ready in request cycle", {31'd0, data_ready}, 32'd1);
      data_in = v.val ^ 24'(p);
      if (v.dly != 0) repeat (int'(v.dly)) @(negedge clk);
      data_valid = 1'b1;
      forever begin
        if (data_ready) begin @(negedge clk); break; end
        if (now == dl) break;
        @(negedge clk);
      end
      data_valid = 1'b0;
      while (now != dl) @(negedge clk);
      chk("R4 output unchanged in deadline cycle", {8'd0, out}, {8'd0, exp_out});
      @(negedge clk);
      if (!v.ur) exp_out = v.val ^ 24'(p);
      chk("R4 output after deadline", {8'd0, out}, {8'd0, exp_out});
      chk("R7 underrun flag", {31'd0, underrun}, {31'd0, v.ur});
    end
  endtask

  initial begin
    logic [31:0] t1;
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    chk("R10 out", {8'd0, out}, 32'd0);
    chk("R10 underrun", {31'd0, underrun}, 32'd0);
    chk("R10 cfg_err", {31'd0, cfg_err}, 32'd0);
    chk("R10 data_req", {31'd0, data_req}, 32'd0);
    chk("R10 data_ready", {31'd0, data_ready}, 32'd0);
    chk("R1 reset value", now, T_INIT);
    @(negedge clk);
    chk("R1 count step", now, T_INIT + 32'd1);

    // R9: first deadline lies past the wrap point
    run_vec('{32'd300, 8'd32, 8'd3, 24'h5A5A5A, 1'b0});
    chk("R9 wrapped deadline updated output", {8'd0, out}, {8'd0, 24'h5A5A5B});

    // table walk
    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R1: start does not disturb the count
    @(negedge clk);
    t1 = now; start = 1'b1; interval = 32'd50; lead = 8'd5;
    @(negedge clk);
    start = 1'b0;
    chk("R1 count across start", now, t1 + 32'd1);
    // R6: valid offered before the window is ignored
    data_in = 24'h777777; data_valid = 1'b1;
    repeat (10) @(negedge clk);
    data_valid = 1'b0;
    while (now != t1 + 32'd51) @(negedge clk);
    chk("R6 early word ignored, output held", {8'd0, out}, {8'd0, exp_out});
    chk("R6 R7 early word ignored, underrun", {31'd0, underrun}, 32'd1);

    // R8: illegal configurations
    @(negedge clk);
    start = 1'b1; interval = 32'd4; lead = 8'd4;
    @(negedge clk);
    start = 1'b0;
    chk("R8 cfg_err on interval<=lead", {31'd0, cfg_err}, 32'd1);
    wait_req(ok);
    chk("R8 no request when idle", {31'd0, ok}, 32'd0);
    chk("R8 output unchanged when idle", {8'd0, out}, {8'd0, exp_out});
    start = 1'b1; interval = 32'd30; lead = 8'd0;
    @(negedge clk);
    start = 1'b0;
    chk("R8 cfg_err on zero lead", {31'd0, cfg_err}, 32'd1);
    run_vec('{32'd30, 8'd6, 8'd2, 24'h3C3C3C, 1'b0});
    chk("R8 cfg_err cleared by legal start", {31'd0, cfg_err}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule